// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt events from fourteen on-chip sources and one external legacy line. It presents a single interrupt request to a CPU core. When the core runs its acknowledge cycle, the block answers with a vector byte, so the core never reads an undriven data bus. Every source latches its event into a pending bit. Software reads those bits back and clears them with write-1-to-clear writes. A per-source enable decides whether a pending bit can request the CPU. A second, separate enable set selects which pending bits drive an interrupt line toward a DMA engine.

The block has two modes. In shared-pulse mode, every enabled pending source is ORed onto the request line, and the acknowledge cycle has no effect on the block's state. In vectored mode, the block behaves like a daisy chain of peripherals. The acknowledge cycle moves the highest-priority eligible source into service and clears its pending bit. Sources of equal or lower priority stay blocked until the core's return-from-interrupt opcode pair (0xED then 0x4D) is seen on opcode fetches. That pair releases the highest-priority source in service, so nested service of more urgent sources unwinds in the right order.

Software reaches the registers through a plain address/write-enable/data port. Reads return data combinationally.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, the control register, all enable registers, all status registers and all DMA enable registers read 0x00. The block is in shared-pulse mode, and both `irq_o` and `dma_irq_o` are low.
- R2: Source priorities are fixed: 0 line, 1 serial-0 receive, 2 serial-1 receive, 3 to 10 timer channels 0 to 7, 11 frame, 12 serial-0 transmit, 13 serial-1 transmit (`src_req` bit n is priority n). In vectored mode, the vector for internal priority p is {ctrl[7:5], p[3:0], 1'b0}. The control register is at address 0, with bits [7:5] as the vector top bits and bit 0 as the mode (1 = vectored).
- R3: When several enabled pending sources are eligible at an acknowledge, the lowest priority number wins.
- R4: The external request (`ext_req`) ranks below every internal source. An acknowledge that selects it, finds nothing eligible, or occurs in shared-pulse mode returns `ext_vec` when `ext_vec_valid` is high, and 0xFF otherwise.
- R5: Status registers are at address 5 (bit0 frame, bit1 line, bit2 external), address 6 (bit k = timer k) and address 7 (bit0 serial-0 rx, bit1 serial-1 rx, bit2 serial-0 tx, bit3 serial-1 tx). Writing 1 clears a bit and writing 0 leaves it unchanged. Events are latched even when the source is disabled.
- R6: In shared-pulse mode, `irq_o` is high exactly while some enabled source's status bit is set. An acknowledge changes no pending bit.
- R7: In vectored mode, an acknowledge clears the winner's pending bit and marks it in service. `irq_o` is high only while an enabled pending source has a lower priority number than every source in service.
- R8: A fetch of 0x4D that immediately follows a fetch of 0xED releases the highest-priority source in service. Any other byte fetched in between cancels the pair.
- R9: A new event from a source that is already in service stays pending without requesting. It is presented again once the service is released.
- R10: The CPU enable registers are at addresses 2 to 4, laid out like status addresses 5 to 7. Address 1 is an alias: writing it sets the line enable from bit1 and the frame enable from the inverse of bit2, and reading it returns those two states in the same form.
- R11: The DMA enable registers are at addresses 8 to 10, with the same layout. `dma_irq_o` is high while a pending source has its DMA enable set, independent of the CPU enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 14 | One-cycle event strobes, bit n = priority n |
| ext_req | input | 1 | External legacy event strobe |
| ext_vec_valid | input | 1 | External device supplies a vector this acknowledge |
| ext_vec | input | 8 | Vector supplied by the external device |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ack | input | 1 | CPU acknowledge cycle, one clock |
| ack_vec | output | 8 | Vector byte driven during `ack` |
| fetch_valid | input | 1 | An opcode byte is being fetched |
| fetch_byte | input | 8 | The fetched opcode byte |
| irq_o | output | 1 | Interrupt request to the CPU, active high |
| dma_irq_o | output | 1 | Interrupt request to the DMA engine, active high |

## Verification
Several sources are raised at once in an order that differs from their priority, to show that priority decides the winner and not arrival. A lower-priority event that arrives during service must stay silent until release. A higher-priority event must break through. A re-raised source that is already in service must wait. Opcode streams with a foreign byte between 0xED and 0x4D are contrasted with a clean pair, which separates a true pair detector from one that only remembers a past 0xED. The same status traffic is then repeated in shared-pulse mode and against the DMA mask, to show that the acknowledge leaves pulse-mode state alone and that the two enable sets are independent.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NUM_INT  = 14;
  localparam int NSRC     = NUM_INT + 1;
  localparam int IDXW     = $clog2(NSRC + 1);
  localparam int PRIO_W   = 4;
  localparam int TOP_W    = 3;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int NUM_TMR  = 8;

  localparam int IDX_LINE  = 0;
  localparam int IDX_U0RX  = 1;
  localparam int IDX_U1RX  = 2;
  localparam int IDX_TMR0  = 3;
  localparam int IDX_FRAME = 11;
  localparam int IDX_U0TX  = 12;
  localparam int IDX_U1TX  = 13;
  localparam int IDX_EXT   = NUM_INT;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_ALIAS = 4'd1;
  localparam logic [ADDR_W-1:0] A_EN_A  = 4'd2;
  localparam logic [ADDR_W-1:0] A_EN_T  = 4'd3;
  localparam logic [ADDR_W-1:0] A_EN_U  = 4'd4;
  localparam logic [ADDR_W-1:0] A_ST_A  = 4'd5;
  localparam logic [ADDR_W-1:0] A_ST_T  = 4'd6;
  localparam logic [ADDR_W-1:0] A_ST_U  = 4'd7;
  localparam logic [ADDR_W-1:0] A_DM_A  = 4'd8;
  localparam logic [ADDR_W-1:0] A_DM_T  = 4'd9;
  localparam logic [ADDR_W-1:0] A_DM_U  = 4'd10;

  typedef logic [NSRC-1:0] src_vec_t;

  // Register group (0 misc, 1 timers, 2 serial) of a banked address.
  function automatic logic [1:0] grp_of(input logic [ADDR_W-1:0] a);
    case (a)
      A_EN_T, A_ST_T, A_DM_T: grp_of = 2'd1;
      A_EN_U, A_ST_U, A_DM_U: grp_of = 2'd2;
      default:                grp_of = 2'd0;
    endcase
  endfunction

  // Register byte -> per-source vector.
  function automatic src_vec_t grp_unpack(input logic [1:0] g, input logic [DATA_W-1:0] b);
    src_vec_t m;
    m = '0;
    case (g)
      2'd0: begin
        m[IDX_FRAME] = b[0];
        m[IDX_LINE]  = b[1];
        m[IDX_EXT]   = b[2];
      end
      2'd1: m[IDX_TMR0 +: NUM_TMR] = b;
      2'd2: begin
        m[IDX_U0RX] = b[0];
        m[IDX_U1RX] = b[1];
        m[IDX_U0TX] = b[2];
        m[IDX_U1TX] = b[3];
      end
      default: m = '0;
    endcase
    return m;
  endfunction

  // Per-source vector -> register byte.
  function automatic logic [DATA_W-1:0] grp_pack(input logic [1:0] g, input src_vec_t v);
    logic [DATA_W-1:0] b;
    b = '0;
    case (g)
      2'd0: b = {5'b0, v[IDX_EXT], v[IDX_LINE], v[IDX_FRAME]};
      2'd1: b = v[IDX_TMR0 +: NUM_TMR];
      2'd2: b = {4'b0, v[IDX_U1TX], v[IDX_U0TX], v[IDX_U1RX], v[IDX_U0RX]};
      default: b = '0;
    endcase
    return b;
  endfunction

  function automatic src_vec_t grp_mask(input logic [1:0] g);
    return grp_unpack(g, 8'hFF);
  endfunction

  // Index of lowest set bit, NSRC when empty.
  function automatic logic [IDXW-1:0] lowest_idx(input src_vec_t v);
    logic [IDXW-1:0] r;
    r = IDXW'(NSRC);
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDXW'(i);
    end
    return r;
  endfunction

  function automatic src_vec_t lowest_one(input src_vec_t v);
    return v & (~v + src_vec_t'(1));
  endfunction

  function automatic logic [DATA_W-1:0] vec_build(input logic [TOP_W-1:0] top,
                                                  input logic [PRIO_W-1:0] p);
    return {top, p, 1'b0};
  endfunction
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  src_vec_t            src_set,
  input  src_vec_t            ack_clr,
  output src_vec_t            pend,
  output src_vec_t            en,
  output src_vec_t            dma_en,
  output logic [TOP_W-1:0]    vec_top,
  output logic                mode
);
  src_vec_t          pend_n, en_n, dma_n, w1c;
  logic [TOP_W-1:0]  top_n;
  logic              mode_n;
  logic [1:0]        grp;

  assign grp = grp_of(reg_addr);

  always_comb begin
    en_n   = en;
    dma_n  = dma_en;
    top_n  = vec_top;
    mode_n = mode;
    w1c    = '0;
    if (reg_we) begin
      case (reg_addr)
        A_CTRL: begin
          top_n  = reg_wdata[7:5];
          mode_n = reg_wdata[0];
        end
        A_ALIAS: begin
          en_n[IDX_LINE]  = reg_wdata[1];
          en_n[IDX_FRAME] = ~reg_wdata[2];
        end
        A_EN_A, A_EN_T, A_EN_U:
          en_n = (en & ~grp_mask(grp)) | grp_unpack(grp, reg_wdata);
        A_ST_A, A_ST_T, A_ST_U:
          w1c = grp_unpack(grp, reg_wdata);
        A_DM_A, A_DM_T, A_DM_U:
          dma_n = (dma_en & ~grp_mask(grp)) | grp_unpack(grp, reg_wdata);
        default: ;
      endcase
    end
    // new events take precedence over clears in the same cycle
    pend_n = (pend & ~w1c & ~ack_clr) | src_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      en      <= '0;
      dma_en  <= '0;
      vec_top <= '0;
      mode    <= 1'b0;
    end else begin
      pend    <= pend_n;
      en      <= en_n;
      dma_en  <= dma_n;
      vec_top <= top_n;
      mode    <= mode_n;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:                 reg_rdata = {vec_top, 4'b0, mode};
      A_ALIAS:                reg_rdata = {5'b0, ~en[IDX_FRAME], en[IDX_LINE], 1'b0};
      A_EN_A, A_EN_T, A_EN_U: reg_rdata = grp_pack(grp, en);
      A_ST_A, A_ST_T, A_ST_U: reg_rdata = grp_pack(grp, pend);
      A_DM_A, A_DM_T, A_DM_U: reg_rdata = grp_pack(grp, dma_en);
      default:                reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/vic_reti_det.sv
module vic_reti_det
  import vic_pkg::*;
#(
  parameter logic [DATA_W-1:0] FIRST_BYTE  = 8'hED,
  parameter logic [DATA_W-1:0] SECOND_BYTE = 8'h4D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [DATA_W-1:0] fetch_byte,
  output logic              reti_hit
);
  logic armed;

  assign reti_hit = fetch_valid && armed && (fetch_byte == SECOND_BYTE);

  always_ff @(posedge clk) begin
    if (!rst_n)           armed <= 1'b0;
    else if (fetch_valid) armed <= (fetch_byte == FIRST_BYTE);
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic [TOP_W-1:0]  vec_top,
  input  src_vec_t          pend,
  input  src_vec_t          en,
  input  logic              ack,
  input  logic              ext_vec_valid,
  input  logic [DATA_W-1:0] ext_vec,
  input  logic              reti_hit,
  output logic              irq,
  output logic [DATA_W-1:0] ack_vec,
  output src_vec_t          ack_clr,
  output src_vec_t          isv,
  output logic              ack_take,
  output logic [IDXW-1:0]   win_idx
);
  src_vec_t         cand, isv_n, win_onehot;
  logic [IDXW-1:0]  ceil_idx;
  logic             win_ok;
  logic [DATA_W-1:0] ext_ans;

  assign cand       = pend & en;
  assign win_idx    = lowest_idx(cand);
  assign ceil_idx   = lowest_idx(isv);
  assign win_ok     = (cand != '0) && (win_idx < ceil_idx);
  assign irq        = mode ? win_ok : (cand != '0);
  assign ack_take   = ack && mode && win_ok;
  assign win_onehot = src_vec_t'(1) << win_idx;
  assign ack_clr    = ack_take ? win_onehot : '0;
  assign ext_ans    = ext_vec_valid ? ext_vec : 8'hFF;

  always_comb begin
    if (mode && win_ok && (win_idx != IDXW'(IDX_EXT)))
      ack_vec = vec_build(vec_top, win_idx[PRIO_W-1:0]);
    else
      ack_vec = ext_ans;
  end

  always_comb begin
    isv_n = isv;
    if (reti_hit) isv_n = isv_n & ~lowest_one(isv);
    if (ack_take) isv_n = isv_n | win_onehot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) isv <= '0;
    else        isv <= isv_n;
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_INT-1:0]  src_req,
  input  logic                ext_req,
  input  logic                ext_vec_valid,
  input  logic [DATA_W-1:0]   ext_vec,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                ack,
  output logic [DATA_W-1:0]   ack_vec,
  input  logic                fetch_valid,
  input  logic [DATA_W-1:0]   fetch_byte,
  output logic                irq_o,
  output logic                dma_irq_o
);
  src_vec_t          src_set, ack_clr, pend, en, dma_en, isv;
  logic [TOP_W-1:0]  vec_top;
  logic              mode, reti_hit, ack_take;
  logic [IDXW-1:0]   win_idx;

  assign src_set   = {ext_req, src_req};
  assign dma_irq_o = |(pend & dma_en);

  vic_regs u_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .src_set, .ack_clr, .pend, .en, .dma_en, .vec_top, .mode
  );

  vic_reti_det u_reti (
    .clk, .rst_n, .fetch_valid, .fetch_byte, .reti_hit
  );

  vic_arbiter u_arb (
    .clk, .rst_n, .mode, .vec_top, .pend, .en, .ack, .ext_vec_valid, .ext_vec,
    .reti_hit, .irq(irq_o), .ack_vec, .ack_clr, .isv, .ack_take, .win_idx
  );
endmodule

// File: rtl/vic_checker.sv
module vic_checker
  import vic_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mode,
  input logic              ack_take,
  input logic              irq_o,
  input src_vec_t          isv,
  input src_vec_t          pend,
  input src_vec_t          en,
  input logic              reti_hit,
  input logic              fetch_valid,
  input logic [DATA_W-1:0] fetch_byte,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input src_vec_t          src_set
);
  assert_ack_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |-> irq_o);

  assert_ack_enters_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> (isv != '0));

  assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && ((pend & en) == '0)) |-> !irq_o);

  assert_release_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_hit && (isv != '0) && !ack_take) |=> ($countones(isv) == $countones($past(isv)) - 1));

  assert_pair_broken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && (fetch_byte != 8'hED)) |=> !reti_hit);

  assert_w1c_timers_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == A_ST_T) && (reg_wdata == 8'hFF) && (src_set[10:3] == '0))
      |=> (pend[10:3] == '0));
endmodule

bind vec_irq_ctrl vic_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .ack_take(ack_take), .irq_o(irq_o),
  .isv(isv), .pend(pend), .en(en), .reti_hit(reti_hit), .fetch_valid(fetch_valid),
  .fetch_byte(fetch_byte), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .src_set(src_set)
);

// File: tb/vec_irq_ctrl_tb_top.sv
module vec_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] src_req = '0;
  logic        ext_req = 1'b0;
  logic        ext_vec_valid = 1'b0;
  logic [7:0]  ext_vec = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        ack = 1'b0;
  logic [7:0]  ack_vec;
  logic        fetch_valid = 1'b0;
  logic [7:0]  fetch_byte = '0;
  logic        irq_o, dma_irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vec_irq_ctrl dut_i (
    .clk, .rst_n, .src_req, .ext_req, .ext_vec_valid, .ext_vec,
    .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .ack, .ack_vec,
    .fetch_valid, .fetch_byte, .irq_o, .dma_irq_o
  );

  function automatic logic [7:0] exp_vec(input int top3, input int prio);
    return 8'(top3 * 32 + prio * 2);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [7:0] act, input logic [7:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic raise(input int idx);
    @(negedge clk);
    if (idx == 14) ext_req = 1'b1; else src_req[idx] = 1'b1;
    @(negedge clk);
    ext_req = 1'b0; src_req = '0;
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk);
    ack = 1'b1;
    #1 v = ack_vec;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic fetch(input logic [7:0] b);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_byte = b;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic irq_is(input string tag, input logic exp);
    @(negedge clk);
    #1 chk_eq(tag, {7'b0, irq_o}, {7'b0, exp});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    rd(4'd0, d);  chk_eq("R1 ctrl", d, 8'h00);
    rd(4'd2, d);  chk_eq("R1 en misc", d, 8'h00);
    rd(4'd5, d);  chk_eq("R1 status misc", d, 8'h00);
    rd(4'd10, d); chk_eq("R1 dma serial", d, 8'h00);
    #1 chk_eq("R1 irq", {7'b0, irq_o}, 8'h00);
    chk_eq("R1 dma irq", {7'b0, dma_irq_o}, 8'h00);
  endtask

  task automatic t_vector();
    logic [7:0] v;
    do_reset();
    wr(4'd0, 8'h61); wr(4'd2, 8'h01);
    raise(11);
    irq_is("R2 frame request", 1'b1);
    do_ack(v); chk_eq("R2 frame vector", v, exp_vec(3, 11));
    do_reset();
    wr(4'd0, 8'hE1); wr(4'd3, 8'h04);
    raise(5);
    do_ack(v); chk_eq("R2 timer2 vector", v, exp_vec(7, 5));
  endtask

  task automatic t_priority();
    logic [7:0] v;
    do_reset();
    wr(4'd0, 8'h61); wr(4'd2, 8'h03); wr(4'd3, 8'hFF); wr(4'd4, 8'h0F);
    raise(13); raise(5); raise(0);
    do_ack(v); chk_eq("R3 line wins", v, exp_vec(3, 0));
    irq_is("R7 lower blocked", 1'b0);
    fetch(8'hED); fetch(8'h4D);
    irq_is("R8 release reopens", 1'b1);
    do_ack(v); chk_eq("R3 timer2 next", v, exp_vec(3, 5));
    fetch(8'hED); fetch(8'h4D);
    do_ack(v); chk_eq("R3 serial1 tx last", v, exp_vec(3, 13));
    fetch(8'hED); fetch(8'h4D);
    irq_is("R7 idle after drain", 1'b0);
    do_ack(v); chk_eq("R4 empty ack", v, 8'hFF);
  endtask

  task automatic t_reti_broken();
    logic [7:0] v;
    do_reset();
    wr(4'd0, 8'h61); wr(4'd2, 8'h03);
    raise(0);
    do_ack(v); chk_eq("R3 line vector", v, exp_vec(3, 0));
    raise(11);
    irq_is("R7 frame blocked", 1'b0);
    fetch(8'hED); fetch(8'h00); fetch(8'h4D);
    irq_is("R8 split pair ignored", 1'b0);
    fetch(8'h4D);
    irq_is("R8 lone second byte", 1'b0);
    fetch(8'hED); fetch(8'h4D);
    irq_is("R8 clean pair", 1'b1);
    do_ack(v); chk_eq("R8 frame after release", v, exp_vec(3, 11));
  endtask

  task automatic t_rerequest();
    logic [7:0] v;
    do_reset();
    wr(4'd0, 8'h61); wr(4'd2, 8'h02);
    raise(0);
    do_ack(v); chk_eq("R9 first line", v, exp_vec(3, 0));
    raise(0);
    irq_is("R9 held while in service", 1'b0);
    rd(4'd5, v); chk_eq("R9 still pending", v, 8'h02);
    fetch(8'hED); fetch(8'h4D);
    irq_is("R9 re-presented", 1'b1);
    do_ack(v); chk_eq("R9 second line", v, exp_vec(3, 0));
  endtask

  task automatic t_nesting();
    logic [7:0] v;
    do_reset();
    wr(4'd0, 8'h61); wr(4'd2, 8'h03); wr(4'd4, 8'h08);
    raise(11);
    do_ack(v); chk_eq("R7 frame served", v, exp_vec(3, 11));
    raise(0);
    irq_is("R7 higher breaks in", 1'b1);
    do_ack(v); chk_eq("R7 nested line", v, exp_vec(3, 0));
    raise(13);
    irq_is("R7 lower stays blocked", 1'b0);
    fetch(8'hED); fetch(8'h4D);
    irq_is("R8 frame still served", 1'b0);
    fetch(8'hED); fetch(8'h4D);
    irq_is("R8 both released", 1'b1);
  endtask

  task automatic t_status();
    logic [7:0] v;
    do_reset();
    wr(4'd0, 8'h01);
    raise(4);
    rd(4'd6, v); chk_eq("R5 latched while disabled", v, 8'h02);
    irq_is("R5 disabled no request", 1'b0);
    wr(4'd6, 8'h00); rd(4'd6, v); chk_eq("R5 zero write", v, 8'h02);
    wr(4'd6, 8'hFD); rd(4'd6, v); chk_eq("R5 other bits", v, 8'h02);
    wr(4'd6, 8'h02); rd(4'd6, v); chk_eq("R5 cleared", v, 8'h00);
    raise(12);
    rd(4'd7, v); chk_eq("R5 serial0 tx bit", v, 8'h04);
  endtask

  task automatic t_pulse();
    logic [7:0] v;
    do_reset();
    wr(4'd0, 8'h60); wr(4'd4, 8'h01);
    raise(1);
    irq_is("R6 pulse request", 1'b1);
    do_ack(v); chk_eq("R6 pulse ack vector", v, 8'hFF);
    rd(4'd7, v); chk_eq("R6 ack keeps status", v, 8'h01);
    repeat (3) @(negedge clk);
    irq_is("R6 request held", 1'b1);
    wr(4'd7, 8'h01);
    irq_is("R6 drops after clear", 1'b0);
  endtask

  task automatic t_ext();
    logic [7:0] v;
    do_reset();
    wr(4'd0, 8'h61); wr(4'd2, 8'h04); wr(4'd4, 8'h08);
    raise(14);
    irq_is("R4 ext request", 1'b1);
    @(negedge clk); ext_vec_valid = 1'b1; ext_vec = 8'h3C;
    do_ack(v); chk_eq("R4 supplied vector", v, 8'h3C);
    ext_vec_valid = 1'b0;
    fetch(8'hED); fetch(8'h4D);
    raise(14);
    do_ack(v); chk_eq("R4 ext without vector", v, 8'hFF);
    fetch(8'hED); fetch(8'h4D);
    raise(14); raise(13);
    do_ack(v); chk_eq("R4 ext ranks last", v, exp_vec(3, 13));
  endtask

  task automatic t_alias();
    logic [7:0] v;
    do_reset();
    rd(4'd1, v); chk_eq("R10 alias reset", v, 8'h04);
    wr(4'd1, 8'h02); rd(4'd2, v); chk_eq("R10 alias enables", v, 8'h03);
    wr(4'd1, 8'h04); rd(4'd2, v); chk_eq("R10 alias disables", v, 8'h00);
    wr(4'd2, 8'h01); rd(4'd1, v); chk_eq("R10 alias readback", v, 8'h00);
    wr(4'd4, 8'hFF); rd(4'd4, v); chk_eq("R10 serial enables", v, 8'h0F);
  endtask

  task automatic t_dma();
    logic [7:0] v;
    do_reset();
    wr(4'd0, 8'h01); wr(4'd9, 8'h01);
    raise(3);
    @(negedge clk);
    #1 chk_eq("R11 dma request", {7'b0, dma_irq_o}, 8'h01);
    chk_eq("R11 cpu quiet", {7'b0, irq_o}, 8'h00);
    wr(4'd6, 8'h01);
    @(negedge clk);
    #1 chk_eq("R11 dma after clear", {7'b0, dma_irq_o}, 8'h00);
    raise(4);
    @(negedge clk);
    #1 chk_eq("R11 masked source", {7'b0, dma_irq_o}, 8'h00);
    rd(4'd9, v); chk_eq("R11 dma mask read", v, 8'h01);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_vector();
    t_priority();
    t_reti_broken();
    t_rerequest();
    t_nesting();
    t_status();
    t_pulse();
    t_ext();
    t_alias();
    t_dma();
    finish_run();
  end
endmodule